// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block is the 32-bit status and control word that accompanies a floating-point execution unit. Software reads and writes it through a simple word port. The arithmetic unit reports, for each completed operation, five exception events (invalid, overflow, divide-by-zero, underflow, inexact) and an unimplemented-operation indication. The register keeps per-operation cause bits and sticky accumulated flags. It drives a rounding-mode field and a denormal-flush control back to the arithmetic unit, and it raises a one-cycle trap request when an enabled exception occurs.

A sticky flag accumulates only while its exception is masked. When the exception is enabled, it is reported through the cause bits and the trap request instead. A read-only summary bit gathers the serious flags and leaves inexact out. A small flush stage is included so that the arithmetic unit can pass an operand through it: when flushing is on, a denormal is replaced by a zero with the same sign.

Top module: `fp_status_ctrl`

## Requirements
- R1: After reset, `sw_rdata` reads 0 (round-to-nearest, flush off, all enables, causes and flags clear) and `trap_req` is 0.
- R2: A software write loads bits 1:0 into the rounding mode (0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity) and bit 8 into the flush control. Both read back and drive `round_mode` and `flush_en` from the next cycle.
- R3: A software write loads bits 14:10 as the enables: invalid at bit 10, overflow at 11, divide-by-zero at 12, underflow at 13 and inexact at 14. A 1 enables the exception.
- R4: Cause bits 7:2 hold invalid, overflow, divide-by-zero, underflow, inexact and unimplemented, in that order from bit 2. On each cycle with `op_valid`, they are replaced by `{op_unimpl, op_exc}`, and this takes priority over a software write in the same cycle.
- R5: Without `op_valid`, a software write of 0 to a cause bit clears it, and a write of 1 leaves it unchanged.
- R6: Sticky flags sit at bits 30:26: invalid at 26, overflow at 27, divide-by-zero at 28, underflow at 29 and inexact at 30. A reported exception sets its flag only if its enable, as held before that cycle, is 0. `op_exc` bit order is invalid, overflow, divide-by-zero, underflow, inexact from bit 0.
- R7: A sticky flag stays 1 until software writes 0 to it. Software may write flag bits. A hardware set in the same cycle as a software clear leaves the flag at 1.
- R8: Bit 31 reads as the OR of the invalid, overflow, divide-by-zero and underflow flags. It ignores the inexact flag and ignores writes.
- R9: Bits 9 and 25:15 always read 0, whatever is written to them.
- R10: `trap_req` is 1 for exactly the cycle after an `op_valid` cycle in which an exception with its enable at 1 was reported, or in which `op_unimpl` was 1. Otherwise it is 0.
- R11: `flush_out` equals `flush_in`, except when the flush control is 1 and `flush_in` is a denormal single-precision value (exponent 0, fraction nonzero). In that case it is +0 or -0 with the operand's sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write word |
| sw_rdata | output | 32 | Register read word |
| op_valid | input | 1 | Arithmetic unit completed an operation |
| op_exc | input | 5 | Exceptions raised by that operation |
| op_unimpl | input | 1 | Operation was unimplemented |
| round_mode | output | 2 | Rounding mode for the arithmetic unit |
| flush_en | output | 1 | Denormal flush control |
| flush_in | input | 32 | Operand to be conditioned |
| flush_out | output | 32 | Operand after denormal flush |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The assertions watch, on every cycle, the properties that live at the ports. Flags never fall without a software zero, and masked exceptions always set their flag. Enabled exceptions never set a flag that was clear, and a cause bit cannot rise without an operation. Every trap request traces back to a reported operation, and written control fields appear on the outputs. The bench's reference model is what shows the interplay that takes several steps: the summary leaving inexact out, the enable held before a same-cycle write being the one that governs, hardware winning over a same-cycle software clear, and signed zeros produced by the flush stage.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
    localparam int REG_W     = 32;
    localparam int EXC_N     = 5;
    localparam int CAUSE_N   = EXC_N + 1;
    localparam int RM_W      = 2;
    localparam int RM_LSB    = 0;
    localparam int CAUSE_LSB = 2;
    localparam int FLUSH_BIT = 8;
    localparam int EN_LSB    = 10;
    localparam int FLAG_LSB  = 26;
    localparam int SUM_BIT   = 31;
    // Exceptions that feed the summary bit (all but inexact)
    localparam int SUM_N     = 4;

    typedef struct packed {
        logic [RM_W-1:0]    rmode;
        logic               flush;
        logic [EXC_N-1:0]   en;
        logic [CAUSE_N-1:0] cause;
        logic [EXC_N-1:0]   flag;
        logic               trap;
    } fpsr_state_t;
endpackage

// File: rtl/fpsr_next.sv
module fpsr_next
    import fpsr_pkg::*;
(
    input  fpsr_state_t            st_q,
    input  logic                   sw_we,
    input  logic [REG_W-1:0]       sw_wdata,
    input  logic                   op_valid,
    input  logic [EXC_N-1:0]       op_exc,
    input  logic                   op_unimpl,
    output fpsr_state_t            st_d
);
    logic [EXC_N-1:0] hw_set;
    logic [EXC_N-1:0] sw_flag;

    // Per-exception: set the sticky flag only while the exception is masked
    genvar gi;
    generate
        for (gi = 0; gi < EXC_N; gi++) begin : g_exc
            assign hw_set[gi]  = op_valid & op_exc[gi] & ~st_q.en[gi];
            assign sw_flag[gi] = sw_we ? sw_wdata[FLAG_LSB + gi] : st_q.flag[gi];
        end
    endgenerate

    always_comb begin
        st_d = st_q;

        if (sw_we) begin
            st_d.rmode = sw_wdata[RM_LSB +: RM_W];
            st_d.flush = sw_wdata[FLUSH_BIT];
            st_d.en    = sw_wdata[EN_LSB +: EXC_N];
        end

        // Cause: hardware load wins, otherwise write-0-to-clear
        if (op_valid) begin
            st_d.cause = {op_unimpl, op_exc};
        end else if (sw_we) begin
            st_d.cause = st_q.cause & sw_wdata[CAUSE_LSB +: CAUSE_N];
        end

        // Sticky flags: hardware set dominates a software clear
        st_d.flag = sw_flag | hw_set;

        st_d.trap = op_valid & ((|(op_exc & st_q.en)) | op_unimpl);
    end
endmodule

// File: rtl/fpsr_pack.sv
module fpsr_pack
    import fpsr_pkg::*;
(
    input  fpsr_state_t      st,
    output logic [REG_W-1:0] word
);
    always_comb begin
        word = '0;
        word[RM_LSB +: RM_W]       = st.rmode;
        word[CAUSE_LSB +: CAUSE_N] = st.cause;
        word[FLUSH_BIT]            = st.flush;
        word[EN_LSB +: EXC_N]      = st.en;
        word[FLAG_LSB +: EXC_N]    = st.flag;
        word[SUM_BIT]              = |st.flag[SUM_N-1:0];
    end
endmodule

// File: rtl/fpsr_denorm_flush.sv
module fpsr_denorm_flush #(
    parameter int FP_W  = 32,
    parameter int EXP_W = 8
) (
    input  logic            enable,
    input  logic [FP_W-1:0] val_in,
    output logic [FP_W-1:0] val_out
);
    localparam int FRAC_W = FP_W - EXP_W - 1;

    logic sign;
    logic exp_zero;
    logic frac_nz;

    assign sign     = val_in[FP_W-1];
    assign exp_zero = (val_in[FP_W-2 -: EXP_W] == '0);
    assign frac_nz  = (val_in[FRAC_W-1:0] != '0);

    always_comb begin
        val_out = val_in;
        if (enable && exp_zero && frac_nz) begin
            val_out = '0;
            val_out[FP_W-1] = sign;
        end
    end
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
    import fpsr_pkg::*;
#(
    parameter int FP_W  = 32,
    parameter int EXP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_we,
    input  logic [REG_W-1:0]    sw_wdata,
    output logic [REG_W-1:0]    sw_rdata,
    input  logic                op_valid,
    input  logic [EXC_N-1:0]    op_exc,
    input  logic                op_unimpl,
    output logic [RM_W-1:0]     round_mode,
    output logic                flush_en,
    input  logic [FP_W-1:0]     flush_in,
    output logic [FP_W-1:0]     flush_out,
    output logic                trap_req
);
    fpsr_state_t st_d, st_q;

    fpsr_next u_next (
        .st_q      (st_q),
        .sw_we     (sw_we),
        .sw_wdata  (sw_wdata),
        .op_valid  (op_valid),
        .op_exc    (op_exc),
        .op_unimpl (op_unimpl),
        .st_d      (st_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    fpsr_pack u_pack (
        .st   (st_q),
        .word (sw_rdata)
    );

    fpsr_denorm_flush #(.FP_W(FP_W), .EXP_W(EXP_W)) u_flush (
        .enable  (st_q.flush),
        .val_in  (flush_in),
        .val_out (flush_out)
    );

    assign round_mode = st_q.rmode;
    assign flush_en   = st_q.flush;
    assign trap_req   = st_q.trap;
endmodule

// File: rtl/fpsr_chk.sv
module fpsr_chk
    import fpsr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sw_we,
    input logic [REG_W-1:0] sw_wdata,
    input logic [REG_W-1:0] sw_rdata,
    input logic             op_valid,
    input logic [EXC_N-1:0] op_exc,
    input logic             op_unimpl,
    input logic [RM_W-1:0]  round_mode,
    input logic             flush_en,
    input logic             trap_req
);
    // R2
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (round_mode == $past(sw_wdata[RM_LSB +: RM_W])) &&
                  (flush_en == $past(sw_wdata[FLUSH_BIT])));

    // R10
    trap_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_req) |-> $past(op_valid));

    // R10
    trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_unimpl) |=> trap_req);

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (sw_rdata[9] == 1'b0) && (sw_rdata[25:15] == '0));

    genvar gi;
    generate
        for (gi = 0; gi < EXC_N; gi++) begin : g_bit
            // R7
            flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sw_rdata[FLAG_LSB+gi] && !(sw_we && !sw_wdata[FLAG_LSB+gi]))
                |=> sw_rdata[FLAG_LSB+gi]);
            // R6
            masked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op_valid && op_exc[gi] && !sw_rdata[EN_LSB+gi])
                |=> sw_rdata[FLAG_LSB+gi]);
            // R6
            enabled_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op_valid && op_exc[gi] && sw_rdata[EN_LSB+gi] &&
                 !sw_rdata[FLAG_LSB+gi] && !(sw_we && sw_wdata[FLAG_LSB+gi]))
                |=> !sw_rdata[FLAG_LSB+gi]);
            // R10
            trap_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (op_valid && op_exc[gi] && sw_rdata[EN_LSB+gi]) |=> trap_req);
        end
        for (gi = 0; gi < CAUSE_N; gi++) begin : g_cause
            // R5
            cause_norise_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!op_valid && !sw_rdata[CAUSE_LSB+gi]) |=> !sw_rdata[CAUSE_LSB+gi]);
        end
    endgenerate
endmodule

bind fp_status_ctrl fpsr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_we      (sw_we),
    .sw_wdata   (sw_wdata),
    .sw_rdata   (sw_rdata),
    .op_valid   (op_valid),
    .op_exc     (op_exc),
    .op_unimpl  (op_unimpl),
    .round_mode (round_mode),
    .flush_en   (flush_en),
    .trap_req   (trap_req)
);

// File: tb/sim_fp_status_ctrl.sv
module sim_fp_status_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        op_valid = 1'b0;
    logic [4:0]  op_exc = '0;
    logic        op_unimpl = 1'b0;
    logic [1:0]  round_mode;
    logic        flush_en;
    logic [31:0] flush_in = '0;
    logic [31:0] flush_out;
    logic        trap_req;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    // reference model
    logic [1:0] m_rm;
    logic       m_fs;
    logic [4:0] m_en;
    logic [5:0] m_cause;
    logic [4:0] m_flag;
    logic       m_trap;

    fp_status_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .op_valid(op_valid), .op_exc(op_exc),
        .op_unimpl(op_unimpl), .round_mode(round_mode), .flush_en(flush_en),
        .flush_in(flush_in), .flush_out(flush_out), .trap_req(trap_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] model_word();
        logic [31:0] w = '0;
        w[1:0]   = m_rm;
        w[7:2]   = m_cause;
        w[8]     = m_fs;
        w[14:10] = m_en;
        w[30:26] = m_flag;
        w[31]    = |m_flag[3:0];
        return w;
    endfunction

    function automatic logic [31:0] model_flush(logic fs, logic [31:0] v);
        if (fs && v[30:23] == 8'd0 && v[22:0] != 23'd0) return {v[31], 31'd0};
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic check_all();
        logic [31:0] e = model_word();
        chk("R2 rmode",   {30'd0, sw_rdata[1:0]},  {30'd0, e[1:0]});
        chk("R2 rm out",  {30'd0, round_mode},     {30'd0, m_rm});
        chk("R2 flush",   {31'd0, flush_en},       {31'd0, m_fs});
        chk("R3 enables", {27'd0, sw_rdata[14:10]}, {27'd0, e[14:10]});
        chk("R4 R5 cause", {26'd0, sw_rdata[7:2]}, {26'd0, e[7:2]});
        chk("R6 R7 flags", {27'd0, sw_rdata[30:26]}, {27'd0, e[30:26]});
        chk("R8 summary", {31'd0, sw_rdata[31]},   {31'd0, e[31]});
        chk("R9 reserved", {20'd0, sw_rdata[25:15], sw_rdata[9]}, 32'd0);
        chk("R10 trap",   {31'd0, trap_req},       {31'd0, m_trap});
    endtask

    // one clock: drive at negedge, update model, check after the edge
    task automatic step(logic we, logic [31:0] wd, logic v, logic [4:0] ex, logic un);
        logic [4:0] fl_base;
        @(negedge clk);
        sw_we = we; sw_wdata = wd; op_valid = v; op_exc = ex; op_unimpl = un;
        m_trap  = v && ((|(ex & m_en)) || un);
        fl_base = we ? wd[30:26] : m_flag;
        m_flag  = fl_base | (v ? (ex & ~m_en) : 5'd0);
        if (v)       m_cause = {un, ex};
        else if (we) m_cause = m_cause & wd[7:2];
        if (we) begin
            m_rm = wd[1:0]; m_fs = wd[8]; m_en = wd[14:10];
        end
        @(posedge clk);
        #1;
        check_all();
    endtask

    task automatic idle();
        step(1'b0, 32'd0, 1'b0, 5'd0, 1'b0);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
                finish_up();
            end
        end
    end

    initial begin
        void'($urandom(32'd4177));
        m_rm = 0; m_fs = 0; m_en = 0; m_cause = 0; m_flag = 0; m_trap = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 reset word", sw_rdata, 32'd0);
        chk("R1 reset trap", {31'd0, trap_req}, 32'd0);

        // R2 every rounding mode, flush on/off
        for (int m = 0; m < 4; m++) step(1'b1, {23'd0, m[0], 6'd0, m[1:0]}, 1'b0, 5'd0, 1'b0);
        // R9 write all ones: reserved stays 0, summary ignores write
        step(1'b1, 32'hFFFF_FFFF, 1'b0, 5'd0, 1'b0);
        // R7 clear everything
        step(1'b1, 32'd0, 1'b0, 5'd0, 1'b0);
        // R8 inexact alone does not raise summary
        step(1'b0, 32'd0, 1'b1, 5'b10000, 1'b0);
        // R5 writing ones keeps cause, writing zero clears it
        step(1'b1, 32'h0000_00FC, 1'b0, 5'd0, 1'b0);
        step(1'b1, 32'd0, 1'b0, 5'd0, 1'b0);
        // R6 enable overflow: exception traps, flag not set
        step(1'b1, 32'h0000_0800, 1'b0, 5'd0, 1'b0);
        step(1'b0, 32'd0, 1'b1, 5'b00010, 1'b0);
        // R6 enable written in same cycle as op: old enable governs
        step(1'b1, 32'h0000_0000, 1'b1, 5'b00010, 1'b0);
        // R7 hardware set beats same-cycle software clear
        step(1'b1, 32'd0, 1'b1, 5'b00001, 1'b0);
        // R4 op wins over same-cycle cause write; R10 unimplemented traps
        step(1'b1, 32'd0, 1'b1, 5'd0, 1'b1);
        idle();

        // R11 flush stage
        step(1'b1, 32'h0000_0100, 1'b0, 5'd0, 1'b0);
        flush_in = 32'h0000_0001; #1; chk("R11 +denorm", flush_out, 32'h0000_0000);
        flush_in = 32'h807F_FFFF; #1; chk("R11 -denorm", flush_out, 32'h8000_0000);
        flush_in = 32'h3F80_0000; #1; chk("R11 normal",  flush_out, 32'h3F80_0000);
        flush_in = 32'h8000_0000; #1; chk("R11 zero",    flush_out, 32'h8000_0000);
        step(1'b1, 32'h0000_0000, 1'b0, 5'd0, 1'b0);
        flush_in = 32'h8000_0005; #1; chk("R11 off",     flush_out, 32'h8000_0005);

        // random traffic
        for (int i = 0; i < 600; i++) begin
            logic we = ($urandom_range(0, 3) == 0);
            logic [31:0] wd = $urandom();
            logic v = ($urandom_range(0, 1) == 1);
            logic [4:0] ex = 5'($urandom());
            logic un = ($urandom_range(0, 7) == 0);
            step(we, wd, v, ex, un);
            flush_in = $urandom();
            #1;
            chk("R11 random", flush_out, model_flush(m_fs, flush_in));
        end
        finish_up();
    end
endmodule